// File: doc/BRIEF.md
# LIN Response Byte Capture Buffer

This block sits behind a UART receiver that already frames each character and collects the response part of a LIN frame. After a start-of-response trigger, every byte whose stop bit has been received is stored. The first N bytes are data, and the byte after them is the checksum. N is the configured response length, 1 to 8. Data byte k goes into buffer slot k. The checksum goes into a register of its own. Slots above N keep whatever they held before.

Two status flags report progress. One flag rises once the first data byte has been stored. The other rises once the checksum has been stored. After that, the block ignores incoming bytes until the next trigger. Software reads the slots through an indexed read port with one cycle of latency. It clears the flags with a pulse.

Top module: `lin_resp_buffer`

## Requirements
- R1: Data byte k of a response (k = 1..N) is stored in slot k. Read index k-1 (index 0 for byte 1, index 7 for byte 8) returns it.
- R2: A byte is stored only in a cycle where `byteValid` and `stopDone` are both 1. A `byteValid` without `stopDone` stores nothing and does not advance the byte position.
- R3: The length on `cfgLen` is captured at the trigger. In a response of length N, only slots 1..N are written, and slots above N keep their earlier contents.
- R4: A captured length of 0 or of more than 8 behaves as a length of 8.
- R5: The byte that follows data byte N is stored in the checksum register (`chkByte`) and in no data slot.
- R6: `firstRcvd` is 1 from the cycle after data byte 1 is stored.
- R7: `respDone` is 1 from the cycle after the checksum is stored. Bytes that arrive after that change no slot and no checksum until the next trigger.
- R8: A `respStart` or `flagClear` pulse clears both flags. If `flagClear` comes in the same cycle as a flag set, the set wins.
- R9: `respStart` sets the byte position back to data byte 1. A byte offered in the trigger cycle is ignored. Bytes offered after reset and before the first trigger are ignored.
- R10: After reset, all slots, `chkByte`, `rdData`, `firstRcvd` and `respDone` are 0.
- R11: `rdData` shows the slot selected by `rdIdx` one clock after `rdIdx` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| respStart | input | 1 | Start-of-response trigger pulse |
| cfgLen | input | 4 | Configured data byte count, captured at the trigger |
| byteValid | input | 1 | Received byte strobe |
| stopDone | input | 1 | Stop bit of the offered byte has been received |
| rxByte | input | 8 | Received byte value |
| flagClear | input | 1 | Software clear pulse for both flags |
| rdIdx | input | 3 | Slot select for the read port (0 = slot 1) |
| rdData | output | 8 | Registered slot contents |
| chkByte | output | 8 | Stored checksum byte |
| firstRcvd | output | 1 | First data byte stored |
| respDone | output | 1 | Checksum stored, response complete |

## Verification
The bench uses the default parameters: eight slots of eight bits and a four-bit length field. With these settings every slot can be filled. The length field can also carry the values 0 and 9..15, so the bench can drive both clamp cases. Lengths 8, 4 and 1 are run one after another, which shows that a short response leaves the higher slots untouched.

// File: rtl/lin_resp_pkg.sv
package lin_resp_pkg;
  localparam int CNT_W = 4;

  typedef struct packed {
    logic             wrData;
    logic [CNT_W-1:0] wrIdx;
    logic             wrChk;
  } ctrlStrobe_t;
endpackage

// File: rtl/lin_resp_ctrl.sv
module lin_resp_ctrl
  import lin_resp_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             respStart,
  input  logic [CNT_W-1:0] cfgLen,
  input  logic             byteValid,
  input  logic             stopDone,
  input  logic             flagClear,
  output ctrlStrobe_t      strobe,
  output logic             firstRcvd,
  output logic             respDone
);
  localparam logic [CNT_W-1:0] MAX_LEN = CNT_W'(NUM_SLOTS);

  logic [CNT_W-1:0] byteCnt;
  logic [CNT_W-1:0] lenReg;
  logic [CNT_W-1:0] effLen;
  logic             armed;
  logic             commit;
  logic             setFirst;
  logic             setDone;

  // Lengths of 0 or above the slot count become the full slot count.
  always_comb begin
    if (cfgLen == '0 || cfgLen > MAX_LEN) effLen = MAX_LEN;
    else                                  effLen = cfgLen;
  end

  // A byte counts only with its stop bit, while armed, and never in a trigger cycle.
  assign commit   = armed && byteValid && stopDone && !respStart;
  assign setDone  = commit && (byteCnt == lenReg);
  assign setFirst = commit && (byteCnt == '0) && (lenReg != '0);

  always_comb begin
    strobe.wrData = commit && (byteCnt != lenReg);
    strobe.wrIdx  = byteCnt;
    strobe.wrChk  = setDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt <= '0;
      lenReg  <= MAX_LEN;
      armed   <= 1'b0;
    end else if (respStart) begin
      byteCnt <= '0;
      lenReg  <= effLen;
      armed   <= 1'b1;
    end else if (setDone) begin
      armed   <= 1'b0;
    end else if (commit) begin
      byteCnt <= byteCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstRcvd <= 1'b0;
      respDone  <= 1'b0;
    end else begin
      if (setFirst)                    firstRcvd <= 1'b1;
      else if (respStart || flagClear) firstRcvd <= 1'b0;
      if (setDone)                     respDone  <= 1'b1;
      else if (respStart || flagClear) respDone  <= 1'b0;
    end
  end
endmodule

// File: rtl/lin_resp_datapath.sv
module lin_resp_datapath
  import lin_resp_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int BYTE_W    = 8,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [BYTE_W-1:0] rdData,
  output logic [BYTE_W-1:0] chkByte
);
  logic [BYTE_W-1:0] slotQ [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        slotQ[s] <= '0;
      else if (strobe.wrData && strobe.wrIdx == CNT_W'(s))
        slotQ[s] <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             chkByte <= '0;
    else if (strobe.wrChk) chkByte <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= slotQ[rdIdx];
  end
endmodule

// File: rtl/lin_resp_buffer.sv
module lin_resp_buffer
  import lin_resp_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int BYTE_W    = 8,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              respStart,
  input  logic [CNT_W-1:0]  cfgLen,
  input  logic              byteValid,
  input  logic              stopDone,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              flagClear,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [BYTE_W-1:0] rdData,
  output logic [BYTE_W-1:0] chkByte,
  output logic              firstRcvd,
  output logic              respDone
);
  ctrlStrobe_t strobe;

  lin_resp_ctrl #(.NUM_SLOTS(NUM_SLOTS)) ctrl_i (
    .clk(clk), .rstN(rstN), .respStart(respStart), .cfgLen(cfgLen),
    .byteValid(byteValid), .stopDone(stopDone), .flagClear(flagClear),
    .strobe(strobe), .firstRcvd(firstRcvd), .respDone(respDone)
  );

  lin_resp_datapath #(.NUM_SLOTS(NUM_SLOTS), .BYTE_W(BYTE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxByte(rxByte),
    .rdIdx(rdIdx), .rdData(rdData), .chkByte(chkByte)
  );
endmodule

// File: rtl/lin_resp_buffer_chk.sv
module lin_resp_buffer_chk
  import lin_resp_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              respStart,
  input logic              byteValid,
  input logic              stopDone,
  input logic              flagClear,
  input logic [BYTE_W-1:0] chkByte,
  input logic              firstRcvd,
  input logic              respDone
);
  assert_first_needs_byte_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(firstRcvd) |-> $past(byteValid && stopDone));

  assert_chk_needs_stop_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(byteValid && stopDone) |=> $stable(chkByte));

  assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (respDone && !respStart && !flagClear) |=> respDone);

  assert_chk_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    (respDone && !respStart) |=> $stable(chkByte));

  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    respStart |=> (!respDone && !firstRcvd));

  assert_done_needs_byte_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(respDone) |-> $past(byteValid && stopDone && !respStart));
endmodule

bind lin_resp_buffer lin_resp_buffer_chk #(.BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rstN(rstN), .respStart(respStart), .byteValid(byteValid),
  .stopDone(stopDone), .flagClear(flagClear), .chkByte(chkByte),
  .firstRcvd(firstRcvd), .respDone(respDone)
);

// File: tb/lin_resp_buffer_tb_top.sv
module lin_resp_buffer_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       respStart = 1'b0;
  logic [3:0] cfgLen = 4'd8;
  logic       byteValid = 1'b0;
  logic       stopDone = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic       flagClear = 1'b0;
  logic [2:0] rdIdx = 3'd0;
  logic [7:0] rdData, chkByte;
  logic       firstRcvd, respDone;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  lin_resp_buffer dut_i (
    .clk(clk), .rstN(rstN), .respStart(respStart), .cfgLen(cfgLen),
    .byteValid(byteValid), .stopDone(stopDone), .rxByte(rxByte),
    .flagClear(flagClear), .rdIdx(rdIdx), .rdData(rdData), .chkByte(chkByte),
    .firstRcvd(firstRcvd), .respDone(respDone)
  );

  // Behavioural reference
  int  mSlot [8];
  int  mChk, mRd, mCnt, mLen;
  bit  mArmed, mFirst, mDone;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mSlot[i]) mSlot[i] = 0;
      mChk = 0; mRd = 0; mCnt = 0; mLen = 8;
      mArmed = 0; mFirst = 0; mDone = 0;
    end else begin
      int  rdNew;
      bit  take, setF, setD;
      rdNew = mSlot[rdIdx];
      take  = mArmed && byteValid && stopDone && !respStart;
      setF  = 0; setD = 0;
      if (respStart) begin
        mCnt = 0; mArmed = 1;
        mLen = (cfgLen == 0 || cfgLen > 8) ? 8 : int'(cfgLen);
      end
      if (take) begin
        if (mCnt == mLen) begin
          mChk = rxByte; mArmed = 0; setD = 1;
        end else begin
          mSlot[mCnt] = rxByte;
          if (mCnt == 0) setF = 1;
          mCnt++;
        end
      end
      if (setF) mFirst = 1; else if (respStart || flagClear) mFirst = 0;
      if (setD) mDone = 1;  else if (respStart || flagClear) mDone = 0;
      mRd = rdNew;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      check("R11 rdData",    rdData,    mRd);
      check("R5 chkByte",    chkByte,   mChk);
      check("R6 firstRcvd",  firstRcvd, mFirst);
      check("R7 respDone",   respDone,  mDone);
    end
  end

  task automatic startResp(int len);
    @(negedge clk);
    respStart = 1; cfgLen = 4'(len);
    @(negedge clk);
    respStart = 0;
  endtask

  task automatic offer(int b, bit stop);
    @(negedge clk);
    byteValid = 1; stopDone = stop; rxByte = 8'(b);
    @(negedge clk);
    byteValid = 0; stopDone = 0;
  endtask

  task automatic readSlot(int idx, int exp, string tag);
    @(negedge clk);
    rdIdx = 3'(idx);
    @(negedge clk);
    check(tag, rdData, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R10 reset state
    check("R10 chk", chkByte, 0);
    check("R10 first", firstRcvd, 0);
    check("R10 done", respDone, 0);
    readSlot(5, 0, "R10 slot6");

    // R9 bytes before any trigger ignored
    offer(8'hEE, 1);
    check("R9 pre-trigger first", firstRcvd, 0);
    readSlot(0, 0, "R9 pre-trigger slot1");

    // R1 full 8-byte response
    startResp(8);
    for (int k = 1; k <= 8; k++) begin
      offer(8'h10 + k, 1);
      if (k == 1) check("R6 first after byte1", firstRcvd, 1);
    end
    check("R5 not done before chk", respDone, 0);
    offer(8'hC5, 1);
    check("R5 chk stored", chkByte, 8'hC5);
    check("R7 done", respDone, 1);
    for (int k = 1; k <= 8; k++) readSlot(k - 1, 8'h10 + k, "R1 slot");

    // R7 extra bytes ignored
    offer(8'h77, 1);
    check("R7 chk unchanged", chkByte, 8'hC5);
    readSlot(0, 8'h11, "R7 slot1 unchanged");

    // R8 flagClear clears
    @(negedge clk); flagClear = 1; @(negedge clk); flagClear = 0;
    check("R8 cleared first", firstRcvd, 0);
    check("R8 cleared done", respDone, 0);

    // R3 4-byte response, R2 missing stop bit
    startResp(4);
    check("R8 start clears", respDone, 0);
    offer(8'hA1, 0);
    check("R2 no stop no flag", firstRcvd, 0);
    readSlot(0, 8'h11, "R2 slot1 kept");
    // R8 set wins over flagClear
    @(negedge clk);
    byteValid = 1; stopDone = 1; rxByte = 8'hA1; flagClear = 1;
    @(negedge clk);
    byteValid = 0; stopDone = 0; flagClear = 0;
    check("R8 set wins", firstRcvd, 1);
    offer(8'hA2, 1); offer(8'hA3, 1); offer(8'hA4, 1);
    offer(8'h3C, 1);
    check("R3 chk after 4", chkByte, 8'h3C);
    readSlot(3, 8'hA4, "R3 slot4");
    readSlot(4, 8'h15, "R3 slot5 kept");
    readSlot(7, 8'h18, "R3 slot8 kept");

    // R4 length 0 and 12 act as 8
    startResp(0);
    for (int k = 1; k <= 8; k++) offer(8'h40 + k, 1);
    check("R4 len0 not done at 8", respDone, 0);
    offer(8'h5A, 1);
    check("R4 len0 chk", chkByte, 8'h5A);
    readSlot(7, 8'h48, "R4 len0 slot8");
    startResp(12);
    for (int k = 1; k <= 9; k++) offer(8'h60 + k, 1);
    check("R4 len12 chk", chkByte, 8'h69);
    readSlot(7, 8'h68, "R4 len12 slot8");

    // R9 byte in trigger cycle ignored, restart from slot1, length 1
    @(negedge clk);
    respStart = 1; cfgLen = 4'd1; byteValid = 1; stopDone = 1; rxByte = 8'hBB;
    @(negedge clk);
    respStart = 0; byteValid = 0; stopDone = 0;
    check("R9 trigger byte ignored", firstRcvd, 0);
    offer(8'hD1, 1);
    offer(8'hD2, 1);
    check("R9 len1 chk", chkByte, 8'hD2);
    readSlot(0, 8'hD1, "R9 slot1");
    readSlot(1, 8'h62, "R3 slot2 kept");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule